// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Input

This block sits beside a small 8-bit processor core and decides which interrupt the core takes next. It watches five sources: a non-maskable input (`nmi_n`, active low), two groups of active-low port pins, a timer-zero flag and an A/D end-of-conversion flag. Each source has its own vector.

The two pin groups and the non-maskable input are captured in latches, so a short event is not lost. Pin-group events are latched even while the global enable is off, and they are served once software sets the enable. The two peripheral flags are not latched. They are level requests that the peripheral holds until software clears them, and each is gated by its own enable bit.

When at least one source is serviceable, the controller raises `irq_req` with a 3-bit vector number and a 12-bit program-counter load address. These outputs stay unchanged until the core returns a one-cycle acknowledge. The acknowledge clears the latch of the vector being entered. A wake-up output tells the core's low-power logic that something is pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` is 0, `wake` is 0 and `cfg_rdata` is 0. Pins idle high, and the detectors start in the idle-high state.
- R2: A high-to-low transition on `nmi_n` is passed through a SYNC_STAGES-flop synchronizer and then latched. It requests vector 0 whatever the state of the global enable (cfg bit 0).
- R3: After vector 0 is acknowledged, no further vector 0 request is issued until a `nmi_done` pulse. A falling edge that arrives in that window stays latched and is served after the pulse.
- R4: Maskable vectors (1 to 4) are issued only while cfg bit 0 (global enable) is 1. Port events that occur while it is 0 stay latched and are issued after it is set. Acknowledging vector 1 or 2 clears that group's latch.
- R5: Port group A (vector 1) uses cfg bit 1 and port group B (vector 2) uses cfg bit 2 to select the detection mode. With the bit at 1, a falling edge on any synchronized pin of the group sets the latch. With the bit at 0, any pin held low sets it on every cycle. When an event and the clearing acknowledge coincide, the event wins.
- R6: Vector 3 is requested while `tmr_zero` is 1 and cfg bit 3 is 1. Acknowledging it does not clear the flag, so a flag that is still high is requested again.
- R7: Vector 4 is requested while `adc_eoc` is 1 and cfg bit 4 is 1. Acknowledging it does not clear the flag.
- R8: When several requests are serviceable, the lowest vector number wins: 0, then 1, 2, 3, 4.
- R9: While `irq_req` is 1 and `irq_ack` is 0, `irq_vec` and `irq_addr` stay unchanged, even if the sources or the enables change. The cycle after an acknowledge, `irq_req` is 0.
- R10: `irq_addr` equals VEC_BASE + VEC_STEP × `irq_vec`. With the defaults, vector 0 is at 0xFF0 and each following vector is 2 higher.
- R11: `wake` is 1 whenever any of these holds: an unblocked NMI latch, a port latch, or an enabled peripheral flag. It does not depend on the global enable.
- R12: A write with `cfg_wr` loads `cfg_wdata` into the 5-bit configuration, and `cfg_rdata` returns it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration: bit0 global enable, bit1 group A edge mode, bit2 group B edge mode, bit3 timer enable, bit4 A/D enable |
| cfg_rdata | output | 5 | Current configuration |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge active |
| pa_pins | input | PA_W (3) | Port group A interrupt pins, active low |
| pb_pins | input | PB_W (6) | Port group B interrupt pins, active low |
| tmr_zero | input | 1 | Timer reached-zero flag |
| adc_eoc | input | 1 | A/D end-of-conversion flag |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Vector number being requested |
| irq_addr | output | ADDR_W (12) | Program-counter load address of the vector |
| irq_ack | input | 1 | One-cycle vector-entry acknowledge from the core |
| nmi_done | input | 1 | One-cycle pulse: non-maskable routine has returned |
| wake | output | 1 | Wake-up from stop or wait |

## Verification
The hardest state to reach is a full backlog. In it, the NMI, both port latches and both peripheral flags are pending together while the global enable is off, and the NMI alone slips through. The stimulus builds this backlog with short pin pulses and an NMI edge while the enable is 0. It then raises the enable and acknowledges one vector at a time. Holding the timer flag high starves the A/D vector, and the flag is dropped only to let vector 4 through. A second hard case is an NMI edge that arrives while the NMI routine is still open: it must wait for `nmi_done`. The bench reaches it by issuing the edge between the acknowledge and the return pulse.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int NUM_VEC = 5;
   localparam int VEC_W   = 3;
   localparam int CFG_W   = 5;

   localparam logic [VEC_W-1:0] VEC_NMI   = 3'd0;
   localparam logic [VEC_W-1:0] VEC_PORTA = 3'd1;
   localparam logic [VEC_W-1:0] VEC_PORTB = 3'd2;
   localparam logic [VEC_W-1:0] VEC_TIMER = 3'd3;
   localparam logic [VEC_W-1:0] VEC_ADC   = 3'd4;

   // bit 0 is gie, bit 4 is adc_en
   typedef struct packed {
      logic adc_en;
      logic tmr_en;
      logic pb_edge;
      logic pa_edge;
      logic gie;
   } irq_cfg_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = W * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irqc_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("irqc_sync: W must be at least 1");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {CHAIN_W{RST_VAL}};
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {CHAIN_W{RST_VAL}};
            else        chain <= {chain[CHAIN_W-W-1:0], d};
         end
      end
   endgenerate

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/irqc_port_group.sv
module irqc_port_group #(
   parameter int W      = 3,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pins,
   input  logic         edge_mode,
   input  logic         clr,
   output logic         pend
);
   logic [W-1:0] pin_s;
   logic [W-1:0] pin_prev;
   logic         evt;

   irqc_sync #(.W(W), .STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= '1;
      else        pin_prev <= pin_s;
   end

   // falling edge on any pin, or any pin low
   assign evt = edge_mode ? |(pin_prev & ~pin_s) : |(~pin_s);

   // a new event outranks the clearing acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend <= 1'b0;
      else if (evt) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int N = 5
)(
   input  logic [N-1:0]         req,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int IDX_W = $clog2(N);

   generate
      if (N < 2) begin : g_bad_n
         $error("irqc_prio: N must be at least 2");
      end
   endgenerate

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqc_pkg::*;
#(
   parameter int          PA_W        = 3,
   parameter int          PB_W        = 6,
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_W      = 12,
   parameter int unsigned VEC_BASE    = 32'hFF0,
   parameter int unsigned VEC_STEP    = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              nmi_n,
   input  logic [PA_W-1:0]   pa_pins,
   input  logic [PB_W-1:0]   pb_pins,
   input  logic              tmr_zero,
   input  logic              adc_eoc,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   output logic [ADDR_W-1:0] irq_addr,
   input  logic              irq_ack,
   input  logic              nmi_done,
   output logic              wake
);
   localparam int unsigned TOP_ADDR = VEC_BASE + VEC_STEP * (NUM_VEC - 1);
   localparam int unsigned ADDR_LIM = 32'd1 << ADDR_W;

   generate
      if (ADDR_W < 4 || ADDR_W > 30) begin : g_bad_aw
         $error("irq_vector_ctrl: ADDR_W out of range");
      end
      if (TOP_ADDR >= ADDR_LIM) begin : g_bad_map
         $error("irq_vector_ctrl: vector table does not fit ADDR_W");
      end
      if (PA_W < 1 || PB_W < 1) begin : g_bad_pins
         $error("irq_vector_ctrl: pin groups need at least one pin");
      end
   endgenerate

   irq_cfg_t             cfg_q;
   logic                 req_q;
   logic [VEC_W-1:0]     vec_q;
   logic [ADDR_W-1:0]    addr_q;
   logic                 ack_fire;
   logic [NUM_VEC-1:0]   clr;
   logic [NUM_VEC-1:0]   serv;
   logic                 serv_any;
   logic [VEC_W-1:0]     serv_idx;
   logic                 nmi_s, nmi_prev, nmi_lat, nmi_busy;
   logic                 pa_pend, pb_pend;

   // configuration register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= irq_cfg_t'(cfg_wdata);
   end
   assign cfg_rdata = cfg_q;

   assign ack_fire = req_q & irq_ack;

   generate
      for (genvar v = 0; v < NUM_VEC; v++) begin : g_clr
         assign clr[v] = ack_fire && (vec_q == VEC_W'(v));
      end
   endgenerate

   // non-maskable source
   irqc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nmi_n),
      .q     (nmi_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev <= 1'b1;
         nmi_lat  <= 1'b0;
         nmi_busy <= 1'b0;
      end else begin
         nmi_prev <= nmi_s;
         if (nmi_prev && !nmi_s)  nmi_lat <= 1'b1;
         else if (clr[VEC_NMI])   nmi_lat <= 1'b0;
         if (clr[VEC_NMI])        nmi_busy <= 1'b1;
         else if (nmi_done)       nmi_busy <= 1'b0;
      end
   end

   // port groups
   irqc_port_group #(.W(PA_W), .STAGES(SYNC_STAGES)) u_grp_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins      (pa_pins),
      .edge_mode (cfg_q.pa_edge),
      .clr       (clr[VEC_PORTA]),
      .pend      (pa_pend)
   );

   irqc_port_group #(.W(PB_W), .STAGES(SYNC_STAGES)) u_grp_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins      (pb_pins),
      .edge_mode (cfg_q.pb_edge),
      .clr       (clr[VEC_PORTB]),
      .pend      (pb_pend)
   );

   // serviceable set and selection
   assign serv[VEC_NMI]   = nmi_lat & ~nmi_busy;
   assign serv[VEC_PORTA] = cfg_q.gie & pa_pend;
   assign serv[VEC_PORTB] = cfg_q.gie & pb_pend;
   assign serv[VEC_TIMER] = cfg_q.gie & cfg_q.tmr_en & tmr_zero;
   assign serv[VEC_ADC]   = cfg_q.gie & cfg_q.adc_en & adc_eoc;

   irqc_prio #(.N(NUM_VEC)) u_prio (
      .req (serv),
      .any (serv_any),
      .idx (serv_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         vec_q  <= '0;
         addr_q <= '0;
      end else if (!req_q) begin
         if (serv_any) begin
            req_q  <= 1'b1;
            vec_q  <= serv_idx;
            addr_q <= ADDR_W'(VEC_BASE + VEC_STEP * 32'(serv_idx));
         end
      end else if (irq_ack) begin
         req_q <= 1'b0;
      end
   end

   assign irq_req  = req_q;
   assign irq_vec  = vec_q;
   assign irq_addr = addr_q;

   assign wake = (nmi_lat & ~nmi_busy) | pa_pend | pb_pend
               | (cfg_q.tmr_en & tmr_zero) | (cfg_q.adc_en & adc_eoc);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int          ADDR_W   = 12,
   parameter int unsigned VEC_BASE = 32'hFF0,
   parameter int unsigned VEC_STEP = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic [2:0]        irq_vec,
   input logic [ADDR_W-1:0] irq_addr,
   input logic              irq_ack,
   input logic              gie,
   input logic              nmi_busy,
   input logic              wake
);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !irq_ack |=> irq_req && $stable(irq_vec) && $stable(irq_addr));

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack |=> !irq_req);

   p_addr_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_addr == ADDR_W'(VEC_BASE + VEC_STEP * 32'(irq_vec)));

   p_gie_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) && irq_vec != 3'd0 |-> $past(gie));

   p_nmi_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) && irq_vec == 3'd0 |-> !$past(nmi_busy));

   p_vec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_vec <= 3'd4);

   p_wake_before_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(wake));
endmodule

bind irq_vector_ctrl irqc_checker #(
   .ADDR_W   (ADDR_W),
   .VEC_BASE (VEC_BASE),
   .VEC_STEP (VEC_STEP)
) u_irqc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .irq_vec  (irq_vec),
   .irq_addr (irq_addr),
   .irq_ack  (irq_ack),
   .gie      (cfg_rdata[0]),
   .nmi_busy (nmi_busy),
   .wake     (wake)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
   localparam int PA_W = 3;
   localparam int PB_W = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_wr = 1'b0;
   logic [4:0]      cfg_wdata = '0;
   logic [4:0]      cfg_rdata;
   logic            nmi_n = 1'b1;
   logic [PA_W-1:0] pa_pins = '1;
   logic [PB_W-1:0] pb_pins = '1;
   logic            tmr_zero = 1'b0;
   logic            adc_eoc = 1'b0;
   logic            irq_req;
   logic [2:0]      irq_vec;
   logic [11:0]     irq_addr;
   logic            irq_ack = 1'b0;
   logic            nmi_done = 1'b0;
   logic            wake;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .nmi_n(nmi_n), .pa_pins(pa_pins), .pb_pins(pb_pins),
      .tmr_zero(tmr_zero), .adc_eoc(adc_eoc), .irq_req(irq_req), .irq_vec(irq_vec),
      .irq_addr(irq_addr), .irq_ack(irq_ack), .nmi_done(nmi_done), .wake(wake)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [4:0]      m_cfg;
   logic [PA_W-1:0] m_pa_q [$];
   logic [PB_W-1:0] m_pb_q [$];
   logic            m_n_q [$];
   logic [PA_W-1:0] m_pa_old;
   logic [PB_W-1:0] m_pb_old;
   logic            m_n_old;
   bit m_nlat, m_busy, m_palat, m_pblat, m_req;
   int m_vec, m_addr;

   always @(posedge clk) begin : model
      logic [4:0] p;
      logic [PA_W-1:0] pa_now;
      logic [PB_W-1:0] pb_now;
      logic n_now;
      bit pa_e, pb_e, n_e, fire;
      int sel;
      if (!rst_n) begin
         m_cfg = '0;
         m_pa_q = '{'1, '1}; m_pb_q = '{'1, '1}; m_n_q = '{1'b1, 1'b1};
         m_pa_old = '1; m_pb_old = '1; m_n_old = 1'b1;
         m_nlat = 0; m_busy = 0; m_palat = 0; m_pblat = 0; m_req = 0;
         m_vec = 0; m_addr = 0;
      end else begin
         pa_now = m_pa_q[0]; pb_now = m_pb_q[0]; n_now = m_n_q[0];
         pa_e = m_cfg[1] ? |(m_pa_old & ~pa_now) : |(~pa_now);
         pb_e = m_cfg[2] ? |(m_pb_old & ~pb_now) : |(~pb_now);
         n_e  = m_n_old && !n_now;
         p[0] = m_nlat && !m_busy;
         p[1] = m_cfg[0] && m_palat;
         p[2] = m_cfg[0] && m_pblat;
         p[3] = m_cfg[0] && m_cfg[3] && tmr_zero;
         p[4] = m_cfg[0] && m_cfg[4] && adc_eoc;
         fire = m_req && irq_ack;
         m_nlat  = (m_nlat  && !(fire && m_vec == 0)) || n_e;
         m_palat = (m_palat && !(fire && m_vec == 1)) || pa_e;
         m_pblat = (m_pblat && !(fire && m_vec == 2)) || pb_e;
         if (fire && m_vec == 0) m_busy = 1;
         else if (nmi_done)      m_busy = 0;
         if (!m_req) begin
            sel = -1;
            for (int i = 4; i >= 0; i--) if (p[i]) sel = i;
            if (sel >= 0) begin
               m_req = 1; m_vec = sel; m_addr = 'hFF0 + 2 * sel;
            end
         end else if (irq_ack) begin
            m_req = 0;
         end
         m_pa_old = pa_now; m_pb_old = pb_now; m_n_old = n_now;
         void'(m_pa_q.pop_front()); m_pa_q.push_back(pa_pins);
         void'(m_pb_q.pop_front()); m_pb_q.push_back(pb_pins);
         void'(m_n_q.pop_front());  m_n_q.push_back(nmi_n);
         if (cfg_wr) m_cfg = cfg_wdata;
      end
   end

   always @(posedge clk) begin : compare
      bit exp_wake;
      #1;
      if (rst_n && !finished) begin
         exp_wake = (m_nlat && !m_busy) || m_palat || m_pblat
                 || (m_cfg[3] && tmr_zero) || (m_cfg[4] && adc_eoc);
         check(irq_req == m_req, "R9 req", int'(irq_req), int'(m_req));
         if (m_req) begin
            check(int'(irq_vec) == m_vec, "R8 vec", int'(irq_vec), m_vec);
            check(int'(irq_addr) == m_addr, "R10 addr", int'(irq_addr), m_addr);
         end
         check(wake == exp_wake, "R11 wake", int'(wake), int'(exp_wake));
         check(cfg_rdata == m_cfg, "R12 cfg", int'(cfg_rdata), int'(m_cfg));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr_cfg(input logic [4:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); nmi_done = 1'b1;
      @(negedge clk); nmi_done = 1'b0;
   endtask

   task automatic pulse_nmi();
      @(negedge clk); nmi_n = 1'b0;
      repeat (3) @(negedge clk);
      nmi_n = 1'b1;
   endtask

   task automatic wait_req(input int limit);
      for (int i = 0; i < limit && !irq_req; i++) tick(1);
   endtask

   task automatic drain();
      for (int i = 0; i < 20; i++) begin
         tick(6);
         if (irq_req) do_ack();
      end
   endtask

   // ---------------- directed sequence ----------------
   initial begin : stim
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      check(irq_req == 1'b0, "R1 req", int'(irq_req), 0);
      check(irq_vec == 3'd0, "R1 vec", int'(irq_vec), 0);
      check(wake == 1'b0, "R1 wake", int'(wake), 0);
      check(cfg_rdata == 5'd0, "R1 cfg", int'(cfg_rdata), 0);

      // R2 NMI with global enable off
      pulse_nmi();
      wait_req(12);
      check(irq_req && irq_vec == 3'd0, "R2 nmi vec", int'(irq_vec), 0);
      check(irq_addr == 12'hFF0, "R10 nmi addr", int'(irq_addr), 'hFF0);
      do_ack();
      check(irq_req == 1'b0, "R9 drop after ack", int'(irq_req), 0);
      // R3 re-entry blocked until return pulse
      pulse_nmi();
      tick(10);
      check(irq_req == 1'b0, "R3 blocked", int'(irq_req), 0);
      pulse_done();
      wait_req(12);
      check(irq_req && irq_vec == 3'd0, "R3 after done", int'(irq_vec), 0);
      do_ack();
      pulse_done();

      // R4 port A latched while disabled
      wr_cfg(5'b00010);
      @(negedge clk); pa_pins = 3'b101;
      repeat (3) @(negedge clk); pa_pins = '1;
      tick(8);
      check(irq_req == 1'b0, "R4 held off", int'(irq_req), 0);
      check(wake == 1'b1, "R11 wake while disabled", int'(wake), 1);
      wr_cfg(5'b00011);
      check(cfg_rdata == 5'b00011, "R12 readback", int'(cfg_rdata), 3);
      wait_req(12);
      check(irq_req && irq_vec == 3'd1, "R4 served", int'(irq_vec), 1);
      check(irq_addr == 12'hFF2, "R10 vec1 addr", int'(irq_addr), 'hFF2);
      do_ack();
      tick(6);
      check(irq_req == 1'b0, "R4 latch cleared", int'(irq_req), 0);

      // R5 group B level mode re-raises
      wr_cfg(5'b00001);
      @(negedge clk); pb_pins = 6'b111110;
      wait_req(12);
      check(irq_req && irq_vec == 3'd2, "R5 level", int'(irq_vec), 2);
      do_ack();
      wait_req(12);
      check(irq_req && irq_vec == 3'd2, "R5 level again", int'(irq_vec), 2);
      @(negedge clk); pb_pins = '1;
      drain();
      check(irq_req == 1'b0, "R5 level idle", int'(irq_req), 0);

      // R5 group B edge mode fires once
      wr_cfg(5'b00101);
      @(negedge clk); pb_pins = 6'b011111;
      wait_req(12);
      check(irq_req && irq_vec == 3'd2, "R5 edge", int'(irq_vec), 2);
      do_ack();
      tick(8);
      check(irq_req == 1'b0, "R5 edge once", int'(irq_req), 0);
      @(negedge clk); pb_pins = '1;
      tick(8);
      check(irq_req == 1'b0, "R5 rising ignored", int'(irq_req), 0);

      // R6 timer flag persists across acknowledge
      wr_cfg(5'b01001);
      @(negedge clk); tmr_zero = 1'b1;
      wait_req(12);
      check(irq_req && irq_vec == 3'd3, "R6 timer", int'(irq_vec), 3);
      do_ack();
      wait_req(12);
      check(irq_req && irq_vec == 3'd3, "R6 timer again", int'(irq_vec), 3);
      @(negedge clk); tmr_zero = 1'b0;
      drain();
      wr_cfg(5'b00001);
      @(negedge clk); tmr_zero = 1'b1;
      tick(8);
      check(irq_req == 1'b0, "R6 enable off", int'(irq_req), 0);
      check(wake == 1'b0, "R11 masked flag no wake", int'(wake), 0);
      @(negedge clk); tmr_zero = 1'b0;

      // R8 full backlog
      wr_cfg(5'b11110);
      @(negedge clk); pa_pins = 3'b110; pb_pins = 6'b011111; nmi_n = 1'b0;
      tmr_zero = 1'b1; adc_eoc = 1'b1;
      repeat (3) @(negedge clk);
      pa_pins = '1; pb_pins = '1; nmi_n = 1'b1;
      wait_req(12);
      check(irq_req && irq_vec == 3'd0, "R8 nmi first", int'(irq_vec), 0);
      tick(5);
      check(irq_req && irq_vec == 3'd0, "R9 held", int'(irq_vec), 0);
      do_ack();
      pulse_done();
      tick(4);
      check(irq_req == 1'b0, "R4 backlog gated", int'(irq_req), 0);
      wr_cfg(5'b11111);
      wait_req(12);
      check(irq_req && irq_vec == 3'd1, "R8 group A next", int'(irq_vec), 1);
      wr_cfg(5'b11110);
      tick(3);
      check(irq_req && irq_vec == 3'd1, "R9 held past disable", int'(irq_vec), 1);
      wr_cfg(5'b11111);
      do_ack();
      wait_req(12);
      check(irq_req && irq_vec == 3'd2, "R8 group B next", int'(irq_vec), 2);
      do_ack();
      wait_req(12);
      check(irq_req && irq_vec == 3'd3, "R8 timer before adc", int'(irq_vec), 3);
      do_ack();
      wait_req(12);
      check(irq_req && irq_vec == 3'd3, "R8 adc starved", int'(irq_vec), 3);
      @(negedge clk); tmr_zero = 1'b0;
      do_ack();
      wait_req(12);
      check(irq_req && irq_vec == 3'd4, "R7 adc", int'(irq_vec), 4);
      check(irq_addr == 12'hFF8, "R10 vec4 addr", int'(irq_addr), 'hFF8);
      do_ack();
      wait_req(12);
      check(irq_req && irq_vec == 3'd4, "R7 flag not cleared", int'(irq_vec), 4);
      @(negedge clk); adc_eoc = 1'b0;
      drain();
      check(irq_req == 1'b0, "R7 idle", int'(irq_req), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : watchdog
      #(4 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule